// File: doc/BRIEF.md
# Packed Pixel Word Gearbox

This block turns a stream of 28-bit encoded pixel patterns into a dense stream of 32-bit words with no padding between pixels. A downstream burst writer or streamer can then fetch whole words back to back. Pixels are written into the output as one continuous bitstream, least significant bit first. Each pixel may be split across two words at a 4-bit boundary. The split point moves by 28 bits per pixel, so the layout repeats every eight pixels, which fill exactly seven words. A line of 64 pixels fills 56 words, which is the size of one burst.

Both sides use valid/ready handshakes. An end-of-line marker travels with the last pixel of a line. If bits are left in the residue register after that pixel, the block emits them as one final word with zeros above them. The next line then starts again at bit 0 of a fresh word. The last word of each line is flagged on the output.

Top module: `pixel_word_packer`

## Requirements
- R1: After reset the residue and the bit-offset counter are zero. out_valid is low and in_ready is high. The first pixel after reset lands at bit 0 of a word.
- R2: Eight consecutive pixels of one line produce exactly seven output words and no extra word.
- R3: Pixel 0 occupies bits 27:0 of word 0. Bits 3:0 of pixel 1 occupy bits 31:28 of word 0. Bits 27:4 of pixel 1 occupy bits 23:0 of word 1.
- R4: Across a line, output bit b of word j equals bit (32j+b) mod 28 of pixel floor((32j+b)/28). This holds for any pattern of in_valid and out_ready.
- R5: A 64-pixel line produces exactly 56 words. out_last is high only on word 55.
- R6: When a line's bit count is not a multiple of 32, the line ends with one extra word. That word holds the remaining bits at the bottom, is zero above them, and has out_last high.
- R7: When a line's length is a multiple of 8 pixels, no extra word is emitted. out_last is high on the word that completes the last pixel.
- R8: While out_valid is high and out_ready is low, out_valid, out_word and out_last hold their values on the next cycle. No bits are lost.
- R9: in_ready is low while an output word is held without out_ready, and while a line-end word is waiting to be sent.
- R10: After a line ends, the residue and the offset are zero. The next line starts at bit 0 of a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel is valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_pixel | input | 28 | Encoded pixel pattern (seven 4-bit nibbles) |
| in_last | input | 1 | Marks the last pixel of a line |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Packed output word |
| out_last | output | 1 | Marks the last word of a line |

## Verification
The hardest case to reach is a line-end pixel that completes one word and also leaves residue bits. That pixel needs two words out of one input beat. The second word must wait in the pending state while the first is still stalled. The stimulus reaches this case with short lines of 2, 3 and 5 pixels, sent while out_ready is held low for several cycles. Long random runs then mix random line lengths with random valid and ready gaps, so the line ends fall at every one of the eight split offsets under back-pressure.

// File: rtl/pxpack_pkg.sv
package pxpack_pkg;

  // Offset into the residue after one pixel is appended.
  function automatic int fill_after(int fill, int pix_w, int word_w);
    int t;
    t = fill + pix_w;
    return (t >= word_w) ? (t - word_w) : t;
  endfunction

  // Does appending a pixel at this offset complete a word.
  function automatic bit makes_word(int fill, int pix_w, int word_w);
    return (fill + pix_w) >= word_w;
  endfunction

endpackage

// File: rtl/pxpack_merge.sv
module pxpack_merge #(
  parameter int PIX_W  = 28,
  parameter int WORD_W = 32,
  parameter int FILL_W = 5
) (
  input  logic [WORD_W-1:0] resid,
  input  logic [FILL_W-1:0] fill,
  input  logic [PIX_W-1:0]  pix,
  output logic [WORD_W-1:0] word_lo,
  output logic [WORD_W-1:0] resid_nx,
  output logic              full
);
  localparam int CAT_W = WORD_W + PIX_W;
  localparam int PAD_W = WORD_W - PIX_W;

  logic [CAT_W-1:0] cat;

  always_comb begin
    cat      = {{PIX_W{1'b0}}, resid} | ({{WORD_W{1'b0}}, pix} << fill);
    full     = pxpack_pkg::makes_word(int'(fill), PIX_W, WORD_W);
    word_lo  = cat[WORD_W-1:0];
    resid_nx = full ? {{PAD_W{1'b0}}, cat[CAT_W-1:WORD_W]} : cat[WORD_W-1:0];
  end
endmodule

// File: rtl/pxpack_oreg.sv
module pxpack_oreg #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              load_last,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last,
  output logic              free
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= load_word;
      out_last  <= load_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last))); // R8
endmodule

// File: rtl/pixel_word_packer.sv
module pixel_word_packer #(
  parameter int PIX_W  = 28,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pixel,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last
);
  localparam int FILL_W = $clog2(WORD_W);

  logic [WORD_W-1:0] resid_q;
  logic [FILL_W-1:0] fill_q;
  logic              flush_pend;

  logic [WORD_W-1:0] word_lo, resid_nx, load_word;
  logic [FILL_W-1:0] fill_nx;
  logic              full, free, accept, emit_word, flush_emit, load, load_last;

  pxpack_merge #(.PIX_W(PIX_W), .WORD_W(WORD_W), .FILL_W(FILL_W)) u_merge (
    .resid(resid_q), .fill(fill_q), .pix(in_pixel),
    .word_lo(word_lo), .resid_nx(resid_nx), .full(full)
  );

  pxpack_oreg #(.WORD_W(WORD_W)) u_oreg (
    .clk(clk), .rst_n(rst_n), .load(load), .load_word(load_word),
    .load_last(load_last), .out_ready(out_ready), .out_valid(out_valid),
    .out_word(out_word), .out_last(out_last), .free(free)
  );

  // Named events for the checks below.
  assign in_ready   = free && !flush_pend;
  assign accept     = in_valid && in_ready;
  assign emit_word  = accept && full;
  assign flush_emit = flush_pend && free;
  assign load       = emit_word || flush_emit;
  assign fill_nx    = FILL_W'(pxpack_pkg::fill_after(int'(fill_q), PIX_W, WORD_W));
  assign load_word  = flush_emit ? resid_q : word_lo;
  assign load_last  = flush_emit || (in_last && (fill_nx == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resid_q    <= '0;
      fill_q     <= '0;
      flush_pend <= 1'b0;
    end else if (flush_emit) begin
      resid_q    <= '0;
      fill_q     <= '0;
      flush_pend <= 1'b0;
    end else if (accept) begin
      resid_q    <= resid_nx;
      fill_q     <= fill_nx;
      flush_pend <= in_last && (fill_nx != '0);
    end
  end

  AST_EMIT_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (fill_q != '0)) |=> out_valid); // R4
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_emit |=> ((fill_q == '0) && !flush_pend)); // R10
  AST_FLUSH_FROM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_pend) |-> $past(accept && in_last)); // R6
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    flush_emit |-> ((resid_q >> fill_q) == '0)); // R6
endmodule

// File: tb/tb_pixel_word_packer.sv
module tb_pixel_word_packer;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 28;
  localparam int WW = 32;
  localparam int MEM = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [PW-1:0] in_pixel = '0;
  logic in_ready, out_valid, out_last;
  logic [WW-1:0] out_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_word_packer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .out_last(out_last)
  );

  logic [PW-1:0] pix_mem [MEM];
  logic          last_mem [MEM];
  int n_load = 0;
  int idx = 0;
  logic [WW-1:0] exp_q[$];
  logic          expl_q[$];
  logic [WW-1:0] cap_w [256];
  logic          cap_l [256];
  int cap_n;
  int total = 0, bad = 0;
  bit dog = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: word j taken from the flat LSB-first bitstream of the line.
  function automatic logic [WW-1:0] ref_word(int base, int len, int j);
    logic [WW-1:0] w;
    for (int b = 0; b < WW; b++) begin
      int g;
      g = j*WW + b;
      w[b] = (g < len*PW) ? pix_mem[base + g/PW][g%PW] : 1'b0;
    end
    return w;
  endfunction

  task automatic add_line(input int len);
    int base, nw;
    base = n_load;
    for (int i = 0; i < len; i++) begin
      pix_mem[n_load] = PW'({$urandom, $urandom});
      last_mem[n_load] = (i == len-1);
      n_load++;
    end
    nw = (len*PW + WW - 1) / WW;
    for (int j = 0; j < nw; j++) begin
      exp_q.push_back(ref_word(base, len, j));
      expl_q.push_back(j == nw-1);
    end
  endtask

  // vp/rp: percent chance of in_valid / out_ready per cycle; stall: cycles of forced out_ready low at start
  task automatic run(input int vp, input int rp, input int stall);
    bit hold_prev = 0;
    logic [WW-1:0] w_prev = '0;
    int guard = 0;
    cap_n = 0;
    while ((idx < n_load || exp_q.size() != 0) && !dog) begin
      bit acc, xfer;
      @(negedge clk);
      in_valid  = (idx < n_load) && (($urandom % 100) < vp);
      in_pixel  = pix_mem[idx % MEM];
      in_last   = last_mem[idx % MEM];
      out_ready = (guard >= stall) && (($urandom % 100) < rp);
      #1;
      if (hold_prev)
        chk(out_valid && out_word == w_prev, "R8 hold", {31'd0, out_valid, out_word}, {32'd1, w_prev});
      if (out_valid && !out_ready)
        chk(!in_ready, "R9 in_ready while held", in_ready, 0);
      hold_prev = out_valid && !out_ready;
      w_prev = out_word;
      acc  = in_valid && in_ready;
      xfer = out_valid && out_ready;
      if (xfer) begin
        if (exp_q.size() == 0) chk(0, "R7 unexpected word", out_word, 0);
        else begin
          logic [WW-1:0] e;
          logic el;
          e = exp_q.pop_front();
          el = expl_q.pop_front();
          chk(out_word == e && out_last == el, "R4 word/last", {out_last, out_word}, {el, e});
        end
        if (cap_n < 256) begin cap_w[cap_n] = out_word; cap_l[cap_n] = out_last; end
        cap_n++;
      end
      @(posedge clk);
      if (acc) idx++;
      guard++;
      if (guard > 20000) begin dog = 1; chk(0, "watchdog", guard, 0); end
    end
    @(negedge clk);
    in_valid = 0; out_ready = 1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(!out_valid, "R7 no extra word", out_valid, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R1 reset out_valid", out_valid, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(in_ready && !out_valid, "R1 idle after reset", {in_ready, out_valid}, 2'b10);

    // R2/R3: one 8-pixel line, free-flowing
    add_line(8);
    run(100, 100, 0);
    chk(cap_n == 7, "R2 eight pixels -> seven words", cap_n, 7);
    chk(cap_w[0][27:0] == pix_mem[0], "R3 pixel0 in word0", cap_w[0][27:0], pix_mem[0]);
    chk(cap_w[0][31:28] == pix_mem[1][3:0], "R3 pixel1 low nibble", cap_w[0][31:28], pix_mem[1][3:0]);
    chk(cap_w[1][23:0] == pix_mem[1][27:4], "R3 pixel1 rest in word1", cap_w[1][23:0], pix_mem[1][27:4]);
    chk(cap_l[6] && !cap_l[5], "R7 last on 7th word", {cap_l[5], cap_l[6]}, 2'b01);

    // R5: 64-pixel group
    add_line(64);
    run(80, 70, 0);
    chk(cap_n == 56, "R5 group word count", cap_n, 56);
    chk(cap_l[55], "R5 last on word 55", cap_l[55], 1);

    // R6: 13 pixels = 364 bits, 12 words, top 20 bits of last zero
    add_line(13);
    run(100, 100, 0);
    chk(cap_n == 12 && cap_l[11], "R6 partial line end", {cap_l[11], 31'(cap_n)}, {1'b1, 31'd12});
    chk(cap_w[11][31:12] == '0, "R6 zero fill", cap_w[11][31:12], 0);

    // Hard corner: line end makes a word and leaves residue while output stalls
    add_line(2); add_line(3); add_line(5);
    run(100, 50, 6);
    chk(cap_n == 2+3+5, "R10 short lines under stall", cap_n, 10);

    // R10: new line after a flush starts at bit 0
    add_line(1);
    add_line(9);
    run(100, 100, 0);
    chk(cap_w[0][27:0] == pix_mem[n_load-10] && cap_w[0][31:28] == 4'h0, "R10 single pixel line", cap_w[0], pix_mem[n_load-10]);
    chk(cap_w[1][27:0] == pix_mem[n_load-9], "R10 restart at bit 0", cap_w[1][27:0], pix_mem[n_load-9]);

    // Random lines with random gaps and back-pressure
    for (int t = 0; t < 30 && !dog; t++) begin
      if (n_load > MEM - 80) begin n_load = 0; idx = 0; end
      add_line(1 + int'($urandom % 70));
      run(30 + int'($urandom % 70), 20 + int'($urandom % 80), int'($urandom % 4));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule